// File: doc/BRIEF.md
# Per-Burst Interface CRC Checker

This block runs beside the word path of a synchronous burst link. It folds every 16-bit data word that crosses the link into a 16-bit CRC. The generator polynomial is x^16 + x^12 + x^5 + 1. When the sender closes the burst, it supplies the CRC it computed on its own side. The block compares that value with its own result and reports the outcome.

Each end of the link carries its own instance, and each instance checks the value that it receives. Checking is enforced only in the faster transfer modes. In those modes a mismatch sets an interface-CRC error flag that stays set until control logic clears it. Control logic may then choose to abort the command.

Data words arrive on a valid/ready stream. A word is taken on a rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` is high only while a burst is open, and it is low in any cycle that carries `burst_start` or `burst_end`. The sender holds `in_data` stable while `in_valid` is high and `in_ready` is low. Words offered outside a burst are never taken, so they stall rather than being lost. Burst boundaries, the received CRC, the mode, the clear input and the result are plain level or pulse pins.

Top module: `icrc_burst_checker`

## Requirements
- R1: For each accepted word, the running CRC advances by one whole 16-bit word in a single cycle. The word is fed most significant bit first, with polynomial 0x1021, no bit reflection and no final inversion.
- R2: A `burst_start` pulse reloads the CRC with the seed 16'h4ABA and opens a burst, including when a burst is already open. `in_ready` is high only while a burst is open, and it is low in any cycle where `burst_start` or `burst_end` is high.
- R3: A `burst_end` pulse during an open burst closes the burst. In the cycle after that pulse, `done_valid` is high for exactly one cycle.
- R4: While `done_valid` is high, `done_match` is 1 when `rx_crc`, sampled together with `burst_end`, equals the CRC over the burst's accepted words. Otherwise `done_match` is 0. A burst with no words matches the seed.
- R5: A mismatch in a burst closed with `xfer_mode` >= 3 sets `crc_err`. The flag becomes visible in the same cycle as `done_valid`.
- R6: A mismatch in a burst closed with `xfer_mode` < 3 leaves `crc_err` unchanged, and `done_match` still reads 0.
- R7: `crc_err` is sticky. A later matching burst does not clear it.
- R8: An `err_clear` pulse clears `crc_err` in the next cycle. If a checked mismatch completes in the same cycle as the clear, the flag stays set.
- R9: Words offered while no burst is open are not accepted and do not change the CRC of the next burst.
- R10: A `burst_end` pulse while no burst is open produces no `done_valid` and no change to `crc_err`.
- R11: After reset, `crc_err`, `done_valid` and `in_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start | input | 1 | Pulse: open a burst and reload the seed |
| burst_end | input | 1 | Pulse: close the burst and compare |
| xfer_mode | input | 3 | Transfer mode, sampled with `burst_end` |
| rx_crc | input | 16 | CRC received from the link partner, sampled with `burst_end` |
| in_valid | input | 1 | Data word valid |
| in_ready | output | 1 | Word accepted when high together with `in_valid` |
| in_data | input | 16 | Data word |
| err_clear | input | 1 | Pulse: clear the error flag |
| done_valid | output | 1 | One-cycle pulse: a comparison result is ready |
| done_match | output | 1 | Comparison result, valid with `done_valid` |
| crc_err | output | 1 | Sticky interface-CRC error flag |

## Verification
A wrong seed, a wrong word-step network or a missed word leaves the running state wrong. That error stays hidden until the burst closes, and then shows as `done_match` low one cycle after `burst_end`. In a checked mode it also raises `crc_err` in that same cycle. Every close is therefore compared against a reference CRC, over random word streams with random gaps and deliberately corrupted CRC values. A stale burst flag shows more directly: `in_ready` has the wrong level outside a burst, or `done_valid` appears after a `burst_end` that had no open burst.

// File: rtl/icrc_pkg.sv
package icrc_pkg;
  localparam int                CRC_W        = 16;
  localparam logic [CRC_W-1:0]  CRC_POLY     = 16'h1021;
  localparam logic [CRC_W-1:0]  CRC_SEED     = 16'h4ABA;
  localparam int                MODE_W       = 3;
  localparam int                MIN_CHK_MODE = 3;
endpackage

// File: rtl/crc_word_step.sv
// Combinational next state for one whole word, MSB first (R1).
module crc_word_step #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   POLY = 16'h1021
) (
  input  logic [W-1:0] crc_in,
  input  logic [W-1:0] word,
  output logic [W-1:0] crc_out
);
  logic [W-1:0] stage [W+1];

  assign stage[0] = crc_in;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][W-1] ^ word[W-1-i];
    assign stage[i+1] = {stage[i][W-2:0], 1'b0} ^ ({W{fb}} & POLY);
  end

  assign crc_out = stage[W];
endmodule

// File: rtl/crc_accum.sv
// Running CRC register: reload on start, advance per accepted word.
module crc_accum #(
  parameter int           W    = 16,
  parameter logic [W-1:0] SEED = 16'h4ABA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] next_val,
  output logic [W-1:0] crc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= SEED;
    else if (load) crc_q <= SEED;
    else if (step) crc_q <= next_val;
  end
endmodule

// File: rtl/icrc_flag.sv
// Comparison, result pulse and sticky error flag.
module icrc_flag #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         close_fire,
  input  logic [W-1:0] local_crc,
  input  logic [W-1:0] peer_crc,
  input  logic         check_en,
  input  logic         clear,
  output logic         res_valid,
  output logic         res_match,
  output logic         err_q
);
  logic same;
  logic set_err;

  assign same    = (local_crc == peer_crc);
  assign set_err = close_fire && !same && check_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_match <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      res_valid <= close_fire;
      if (close_fire) res_match <= same;
      if (set_err)    err_q <= 1'b1;   // set wins over clear
      else if (clear) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/icrc_burst_checker.sv
module icrc_burst_checker
  import icrc_pkg::*;
#(
  parameter int                DATA_W    = CRC_W,
  parameter logic [DATA_W-1:0] POLY      = CRC_POLY,
  parameter logic [DATA_W-1:0] SEED      = CRC_SEED,
  parameter int                M_W       = MODE_W,
  parameter int                CHK_FROM  = MIN_CHK_MODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_start,
  input  logic              burst_end,
  input  logic [M_W-1:0]    xfer_mode,
  input  logic [DATA_W-1:0] rx_crc,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              err_clear,
  output logic              done_valid,
  output logic              done_match,
  output logic              crc_err
);
  localparam logic [M_W-1:0] CHK_MODE = M_W'(CHK_FROM);

  logic              in_burst;
  logic              close_fire;
  logic              take_word;
  logic [DATA_W-1:0] crc_q;
  logic [DATA_W-1:0] crc_next;

  assign in_ready   = in_burst && !burst_start && !burst_end;
  assign take_word  = in_valid && in_ready;
  assign close_fire = burst_end && in_burst && !burst_start;

  always_ff @(posedge clk) begin
    if (!rst_n)           in_burst <= 1'b0;
    else if (burst_start) in_burst <= 1'b1;
    else if (burst_end)   in_burst <= 1'b0;
  end

  crc_word_step #(.W(DATA_W), .POLY(POLY)) u_step (
    .crc_in (crc_q),
    .word   (in_data),
    .crc_out(crc_next)
  );

  crc_accum #(.W(DATA_W), .SEED(SEED)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (burst_start),
    .step    (take_word),
    .next_val(crc_next),
    .crc_q   (crc_q)
  );

  icrc_flag #(.W(DATA_W)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .close_fire(close_fire),
    .local_crc (crc_q),
    .peer_crc  (rx_crc),
    .check_en  (xfer_mode >= CHK_MODE),
    .clear     (err_clear),
    .res_valid (done_valid),
    .res_match (done_match),
    .err_q     (crc_err)
  );
endmodule

// File: rtl/icrc_burst_checker_sva.sv
module icrc_burst_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic burst_start,
  input logic burst_end,
  input logic in_ready,
  input logic in_burst,
  input logic err_clear,
  input logic done_valid,
  input logic done_match,
  input logic crc_err
);
  assert_ready_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start || burst_end) |-> !in_ready);

  assert_open_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && !burst_end) |=> (in_burst && !in_ready == (burst_start || burst_end)));

  assert_done_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && in_burst && !burst_start) |=> done_valid);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  assert_no_stray_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_end && in_burst) |=> !done_valid);

  assert_err_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> (done_valid && !done_match));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !err_clear) |=> crc_err);

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !burst_end) |=> !crc_err);
endmodule

bind icrc_burst_checker icrc_burst_checker_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .burst_start(burst_start),
  .burst_end  (burst_end),
  .in_ready   (in_ready),
  .in_burst   (in_burst),
  .err_clear  (err_clear),
  .done_valid (done_valid),
  .done_match (done_match),
  .crc_err    (crc_err)
);

// File: tb/tb_icrc_burst_checker.sv
`timescale 1ns/1ps
module tb_icrc_burst_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_start = 1'b0, burst_end = 1'b0;
  logic [2:0]  xfer_mode = 3'd0;
  logic [15:0] rx_crc = 16'h0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = 16'h0;
  logic        err_clear = 1'b0;
  logic        done_valid, done_match, crc_err;

  int n_tests = 0, n_fail = 0;
  logic [15:0] crc_exp;
  logic        err_exp = 1'b0;

  always #2.5 clk = ~clk;

  icrc_burst_checker dut (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .burst_end(burst_end),
    .xfer_mode(xfer_mode), .rx_crc(rx_crc), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .err_clear(err_clear), .done_valid(done_valid),
    .done_match(done_match), .crc_err(crc_err)
  );

  // Reference: xor word into the register, then 16 shift/reduce steps.
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r = c ^ w;
    for (int k = 0; k < 16; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic open_burst();
    burst_start = 1'b1;
    #0.5 chk("R2 ready low on start", in_ready, 0);
    step();
    burst_start = 1'b0;
    crc_exp = 16'h4ABA;
    #0.5 chk("R2 ready high in burst", in_ready, 1);
  endtask

  task automatic send_word(input logic [15:0] w);
    in_valid = 1'b1; in_data = w;
    step();
    in_valid = 1'b0;
    crc_exp = ref_crc(crc_exp, w);
  endtask

  task automatic close_burst(input logic [15:0] rx, input logic [2:0] m, input logic clr);
    logic match;
    burst_end = 1'b1; rx_crc = rx; xfer_mode = m; err_clear = clr;
    #0.5 chk("R2 ready low on end", in_ready, 0);
    step();
    burst_end = 1'b0; err_clear = 1'b0;
    match = (rx == crc_exp);
    if (!match && m >= 3) err_exp = 1'b1;
    else if (clr) err_exp = 1'b0;
    chk("R3 done pulse", done_valid, 1);
    chk(match ? "R4 match" : "R4/R6 mismatch", done_match, match);
    chk(m >= 3 ? "R5/R7/R8 err" : "R6/R8 err unchecked", crc_err, err_exp);
    step();
    chk("R3 single pulse", done_valid, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R11 err", crc_err, 0);
    chk("R11 done", done_valid, 0);
    chk("R11 ready", in_ready, 0);

    // R10: stray end
    burst_end = 1'b1; rx_crc = 16'h1234; xfer_mode = 3'd5;
    step(); burst_end = 1'b0;
    chk("R10 no done", done_valid, 0);
    chk("R10 no err", crc_err, 0);

    // R4: empty burst matches seed
    open_burst();
    close_burst(16'h4ABA, 3'd4, 1'b0);

    // R6: unchecked mode mismatch
    open_burst(); send_word(16'h0000);
    close_burst(crc_exp ^ 16'h0001, 3'd2, 1'b0);

    // R5: checked mismatch
    open_burst(); send_word(16'hFFFF); send_word(16'h8001);
    close_burst(crc_exp ^ 16'h8000, 3'd3, 1'b0);

    // R7: matching burst keeps err
    open_burst(); send_word(16'h1234);
    close_burst(crc_exp, 3'd6, 1'b0);

    // R8: clear
    err_clear = 1'b1; step(); err_clear = 1'b0; err_exp = 1'b0;
    chk("R8 cleared", crc_err, 0);

    // R8: set beats clear in same cycle
    open_burst(); send_word(16'hA5A5);
    close_burst(~crc_exp, 3'd7, 1'b1);
    err_clear = 1'b1; step(); err_clear = 1'b0; err_exp = 1'b0;
    chk("R8 cleared again", crc_err, 0);

    // R9: offers outside a burst are not taken
    in_valid = 1'b1; in_data = 16'hDEAD;
    #0.5 chk("R9 ready low idle", in_ready, 0);
    repeat (3) step();
    in_valid = 1'b0;
    open_burst(); send_word(16'h0F0F);
    close_burst(crc_exp, 3'd5, 1'b0);

    // R2: restart mid-burst reloads the seed
    open_burst(); send_word(16'h5555); send_word(16'h7777);
    open_burst(); send_word(16'h3C3C);
    close_burst(crc_exp, 3'd5, 1'b0);

    // R1: random bursts with gaps and corrupted CRC values
    for (int b = 0; b < 60; b++) begin
      int len = $urandom_range(0, 20);
      logic [15:0] rx;
      open_burst();
      for (int j = 0; j < len; j++) begin
        if ($urandom_range(0, 3) == 0) step();
        send_word(16'($urandom));
      end
      rx = ($urandom_range(0, 3) == 0) ? (crc_exp ^ 16'(1 << $urandom_range(0, 15))) : crc_exp;
      close_burst(rx, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 4) == 0));
      chk("R1 burst end state", in_ready, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule